// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O port for a system bus that completes each access in a single cycle. It has as many lines as its register is wide. Each line has one pad output, one pad output-enable and one pad input. Software reads the synchronized pin levels through a read-only data register. It drives the lines through an output register, and it chooses which lines drive their pads through a direction register.

Four elaboration-time choices select the variant:
- The width of the register: 8, 16, 32 or 64 bits.
- The output update style. With a companion clear register, writing ones sets bits. Without one, the output register is loaded directly.
- The meaning of a 1 in the direction register. It can mean output, or it can mean input. A third setting removes the direction register, and every line then drives continuously.
- The bit order. An optional mirrored order places line 0 at the most significant bit of every register.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: After reset the output register and the direction register hold zero. pad_out is all zeros. pad_oe is all zeros when a 1 in the direction register means output. pad_oe is all ones when a 1 means input, and all ones when there is no direction register.
- R2: A read of the data register (address 0) returns the level that pad_in held two rising edges before. A read one edge after a change still returns the previous level.
- R3: When a clear register is present, writing the output register (address 1) sets to 1 each line whose written bit is 1. Lines whose written bit is 0 keep their value.
- R4: Writing the clear register (address 2) sets to 0 each line whose written bit is 1. Lines whose written bit is 0 keep their value.
- R5: When no clear register is present, writing the output register loads the written value into every line, so a written 0 drives that line low.
- R6: A write to the direction register (address 3) updates pad_oe at the next edge. A 1 enables the pad driver when a 1 means output. A 1 disables the pad driver when a 1 means input. The register reads back the value written.
- R7: A read of the output register returns, per line, the driven output value for a line whose pad is enabled and the synchronized pin level for a line whose pad is disabled.
- R8: With mirrored order, line n is bit WIDTH-1-n in the data, output, clear and direction registers.
- R9: With no direction register, pad_oe stays all ones. Address 3 then reads as zero, and writes to it have no effect.
- R10: Reads of the clear register, of addresses 4 to 7, or of any address that is not present in the configuration return zero. Writes to the data register or to such addresses change neither pad_out nor pad_oe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational, zero when not reading |
| pad_in | input | WIDTH | Pad input levels, line n on bit n |
| pad_out | output | WIDTH | Pad output values, line n on bit n |
| pad_oe | output | WIDTH | Pad driver enables, line n on bit n |

## Verification
A register write takes effect at the rising edge on which it is presented. The bench therefore checks pad_out and pad_oe at the next falling edge, after exactly one register stage. Read data comes from the current register state without a register stage, so the bench samples it 1 ns after it drives a read at a falling edge. A change on pad_in passes through two flops before it is visible. The bench waits two full cycles after each pin change before it reads the data register or the output register. It also probes the exact latency: it reads at zero, one and two edges after a change and expects the old value, the old value and then the new value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Meaning of a set bit in the direction register.
  typedef enum logic [1:0] {
    DIR_NONE       = 2'd0,
    DIR_ONE_IS_OUT = 2'd1,
    DIR_ONE_IS_IN  = 2'd2
  } dir_mode_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd3;

  // One strobe per register action, produced by the decoder.
  typedef struct packed {
    logic wr_out;
    logic wr_clr;
    logic wr_dir;
    logic rd_data;
    logic rd_out;
    logic rd_dir;
  } reg_hit_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;

endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_pkg::*;
#(
  parameter bit HAS_CLEAR = 1'b1,
  parameter bit HAS_DIR   = 1'b1
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_hit_t          hit
);

  always_comb begin
    hit = '0;
    if (bus_sel) begin
      if (bus_wr) begin
        case (bus_addr)
          OFS_OUT: hit.wr_out = 1'b1;
          OFS_CLR: hit.wr_clr = HAS_CLEAR;
          OFS_DIR: hit.wr_dir = HAS_DIR;
          default: ;
        endcase
      end else begin
        case (bus_addr)
          OFS_DATA: hit.rd_data = 1'b1;
          OFS_OUT:  hit.rd_out  = 1'b1;
          OFS_DIR:  hit.rd_dir  = HAS_DIR;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int WIDTH     = 32,
  parameter bit SET_IS_OR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [WIDTH-1:0] set_mask,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] level_q
);

  logic [WIDTH-1:0] level_d;

  // Next output value; a clear applied in the same cycle as a set wins.
  function automatic logic [WIDTH-1:0] merge_levels(
    input logic [WIDTH-1:0] cur,
    input logic             s_en,
    input logic [WIDTH-1:0] s_val,
    input logic             c_en,
    input logic [WIDTH-1:0] c_val
  );
    logic [WIDTH-1:0] res;
    res = cur;
    if (s_en) res = SET_IS_OR ? (cur | s_val) : s_val;
    if (c_en) res = res & ~c_val;
    return res;
  endfunction

  assign level_d = merge_levels(level_q, set_en, set_mask, clr_en, clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && SET_IS_OR && !clr_en) |=> ((level_q & $past(set_mask)) == $past(set_mask))); // R3
  AST_SET_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && SET_IS_OR && !clr_en) |=> ((level_q & ~$past(set_mask)) == ($past(level_q) & ~$past(set_mask)))); // R3
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((level_q & $past(clr_mask)) == {WIDTH{1'b0}})); // R4
  AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !SET_IS_OR && !clr_en) |=> (level_q == $past(set_mask))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(level_q)); // R3

endmodule

// File: rtl/gpio_dir_latch.sv
module gpio_dir_latch
  import gpio_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter dir_mode_e DIR_MODE = DIR_ONE_IS_OUT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_mask,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] line_oe
);

  generate
    if (DIR_MODE == DIR_NONE) begin : g_bidir
      logic unused_dir_inputs;
      assign unused_dir_inputs = ^{clk, rst_n, wr_en, wr_mask};
      assign dir_q   = '0;
      assign line_oe = '1;
    end else begin : g_reg
      logic [WIDTH-1:0] dir_r;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dir_r <= '0;
        else if (wr_en) dir_r <= wr_mask;
      end

      assign dir_q   = dir_r;
      assign line_oe = (DIR_MODE == DIR_ONE_IS_OUT) ? dir_r : ~dir_r;

      AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dir_r)); // R6
      AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dir_r == $past(wr_mask))); // R6
    end
  endgenerate

endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
  import gpio_pkg::*;
#(
  parameter int        WIDTH     = 32,
  parameter bit        MIRROR    = 1'b0,
  parameter dir_mode_e DIR_MODE  = DIR_ONE_IS_OUT,
  parameter bit        HAS_CLEAR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);

  localparam bit HAS_DIR = (DIR_MODE != DIR_NONE);

  if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
    $error("gpio_mmio_ctrl: WIDTH must be 8, 16, 32 or 64");
  end

  // Register bit <-> line index; the mapping is its own inverse.
  function automatic logic [WIDTH-1:0] map_order(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    r = v;
    if (MIRROR) begin
      for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    end
    return r;
  endfunction

  reg_hit_t         hit;
  logic [WIDTH-1:0] wdata_lines;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] line_oe;
  logic [WIDTH-1:0] rd_lines;

  assign wdata_lines = map_order(bus_wdata);

  gpio_reg_decode #(
    .HAS_CLEAR (HAS_CLEAR),
    .HAS_DIR   (HAS_DIR)
  ) u_decode (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .hit      (hit)
  );

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_out_latch #(
    .WIDTH     (WIDTH),
    .SET_IS_OR (HAS_CLEAR)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (hit.wr_out),
    .set_mask (wdata_lines),
    .clr_en   (hit.wr_clr),
    .clr_mask (wdata_lines),
    .level_q  (out_q)
  );

  gpio_dir_latch #(
    .WIDTH    (WIDTH),
    .DIR_MODE (DIR_MODE)
  ) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (hit.wr_dir),
    .wr_mask (wdata_lines),
    .dir_q   (dir_q),
    .line_oe (line_oe)
  );

  always_comb begin
    rd_lines = '0;
    if (hit.rd_data)     rd_lines = pin_sync;
    else if (hit.rd_out) rd_lines = (out_q & line_oe) | (pin_sync & ~line_oe);
    else if (hit.rd_dir) rd_lines = dir_q;
  end

  assign bus_rdata = map_order(rd_lines);
  assign pad_out   = out_q;
  assign pad_oe    = line_oe;

  // Edges since reset release, saturating; gates the two-deep pin history check.
  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                live_cnt <= '0;
    else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
  end

  AST_DATA_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == 2'd2 && bus_sel && !bus_wr && bus_addr == OFS_DATA)
      |-> (bus_rdata == map_order($past(pad_in, 2)))); // R2
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_DIR && HAS_DIR)
      |=> (pad_oe == ((DIR_MODE == DIR_ONE_IS_OUT) ? map_order($past(bus_wdata))
                                                   : ~map_order($past(bus_wdata))))); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr > OFS_DIR) |-> (bus_rdata == {WIDTH{1'b0}})); // R10
  AST_DATA_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_DATA) |=> ($stable(pad_out) && $stable(pad_oe))); // R10

endmodule

// File: tb/gpio_mmio_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_mmio_ctrl_tb;
  import gpio_pkg::*;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] rd_a, rd_b, rd_c;
  logic [W-1:0] po_a, po_b, po_c;
  logic [W-1:0] oe_a, oe_b, oe_c;

  always #2 clk = ~clk;

  // A: plain order, 1 = output, with clear register
  gpio_mmio_ctrl #(.WIDTH(W), .MIRROR(1'b0), .DIR_MODE(DIR_ONE_IS_OUT), .HAS_CLEAR(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pad_in(pad_in), .pad_out(po_a), .pad_oe(oe_a));
  // B: mirrored order, 1 = input, with clear register
  gpio_mmio_ctrl #(.WIDTH(W), .MIRROR(1'b1), .DIR_MODE(DIR_ONE_IS_IN), .HAS_CLEAR(1'b1)) u_dut_mir (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pad_in(pad_in), .pad_out(po_b), .pad_oe(oe_b));
  // C: plain order, no direction register, plain output register
  gpio_mmio_ctrl #(.WIDTH(W), .MIRROR(1'b0), .DIR_MODE(DIR_NONE), .HAS_CLEAR(1'b0)) u_dut_bidir (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_c), .pad_in(pad_in), .pad_out(po_c), .pad_oe(oe_c));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Line-indexed models
  logic [W-1:0] m_out_a = '0, m_dir_a = '0;
  logic [W-1:0] m_out_b = '0, m_dir_b = '0;
  logic [W-1:0] m_out_c = '0;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    return {v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]};
  endfunction

  function automatic logic [7:0] exp_a(input logic [2:0] a);
    case (a)
      3'd0:    return pad_in;
      3'd1:    return (m_out_a & m_dir_a) | (pad_in & ~m_dir_a);
      3'd3:    return m_dir_a;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_b(input logic [2:0] a);
    logic [7:0] en;
    en = ~m_dir_b;
    case (a)
      3'd0:    return rev8(pad_in);
      3'd1:    return rev8((m_out_b & en) | (pad_in & ~en));
      3'd3:    return rev8(m_dir_b);
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_c(input logic [2:0] a);
    case (a)
      3'd0:    return pad_in;
      3'd1:    return m_out_c;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_pads(input string ta, input string tb, input string tc);
    chk({ta, " A pad_out"}, po_a, m_out_a);
    chk({ta, " A pad_oe"},  oe_a, m_dir_a);
    chk({tb, " B pad_out"}, po_b, m_out_b);
    chk({tb, " B pad_oe"},  oe_b, ~m_dir_b);
    chk({tc, " C pad_out"}, po_c, m_out_c);
    chk({tc, " C pad_oe"},  oe_c, 8'hFF);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic write_all(input logic [2:0] a, input logic [7:0] d,
                           input string ta, input string tb, input string tc);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    case (a)
      3'd1: begin m_out_a |= d; m_out_b |= rev8(d); m_out_c = d; end
      3'd2: begin m_out_a &= ~d; m_out_b &= ~rev8(d); end
      3'd3: begin m_dir_a = d; m_dir_b = rev8(d); end
      default: ;
    endcase
    check_pads(ta, tb, tc);
  endtask

  task automatic read_all(input logic [2:0] a, input string ta, input string tb, input string tc);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk({ta, " A read"}, rd_a, exp_a(a));
    chk({tb, " B read"}, rd_b, exp_b(a));
    chk({tc, " C read"}, rd_c, exp_c(a));
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_pads("R1", "R1", "R1");
    rst_n = 1'b1;
    @(negedge clk);
    read_all(3'd3, "R1 dir", "R1 dir", "R9 dir absent");
    read_all(3'd1, "R1 out", "R1 out", "R1 out");

    // R2: exact latency of the pin path
    pad_in = 8'h5A;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd0;
    #1 chk("R2 edge0 A", rd_a, 8'h00);
    @(negedge clk);
    #1 chk("R2 edge1 A", rd_a, 8'h00);
    @(negedge clk);
    #1 chk("R2 edge2 A", rd_a, 8'h5A);
    chk("R2 edge2 B", rd_b, rev8(8'h5A));
    @(negedge clk);
    bus_sel = 1'b0;

    // R2 / R8: every pin pattern through the data register
    for (int v = 0; v < 256; v++) begin
      pad_in = v[7:0];
      settle();
      read_all(3'd0, "R2 data", "R8 data", "R2 data");
    end

    // R3 / R4 / R5 / R8: output register updates
    write_all(3'd1, 8'h05, "R3 set", "R8 set", "R5 load");
    write_all(3'd1, 8'h30, "R3 set", "R8 set", "R5 load");
    write_all(3'd1, 8'h00, "R3 zero", "R8 zero", "R5 load0");
    write_all(3'd2, 8'h11, "R4 clr", "R8 clr", "R10 clr absent");
    write_all(3'd2, 8'h00, "R4 zero", "R8 zero", "R10 clr absent");
    write_all(3'd1, 8'hC3, "R3 set", "R8 set", "R5 load");

    // R6 / R9: direction register sweep
    for (int d = 0; d < 256; d++) begin
      write_all(3'd3, d[7:0], "R6 dir", "R6 dir", "R9 dir ignored");
    end
    write_all(3'd3, 8'h0F, "R6 dir", "R6 dir", "R9 dir ignored");
    read_all(3'd3, "R6 dir read", "R8 dir read", "R9 dir read");

    // R7: output register readback mixes driven and sampled lines
    foreach (pad_in[k]) begin
      if (k < 4) begin
        pad_in = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'h3C;
        settle();
        read_all(3'd1, "R7 readback", "R7 readback", "R5 readback");
      end
    end

    // R10: unmapped and write-only addresses
    read_all(3'd2, "R10 clr read", "R10 clr read", "R10 clr read");
    for (int a = 4; a < 8; a++) read_all(a[2:0], "R10 unmapped", "R10 unmapped", "R10 unmapped");
    write_all(3'd0, 8'hFF, "R10 data wr", "R10 data wr", "R10 data wr");
    for (int a = 4; a < 8; a++) write_all(a[2:0], 8'hFF, "R10 unmapped wr", "R10 unmapped wr", "R10 unmapped wr");
    read_all(3'd1, "R10 out kept", "R10 out kept", "R10 out kept");
    read_all(3'd3, "R10 dir kept", "R10 dir kept", "R10 dir kept");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule